// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device after a program or erase command has been written. It works out when the embedded operation inside the flash has ended and whether it ended well. It does this by reading a status byte over and over from one fixed address. Bit 6 of that byte flips on every read while the flash is busy. Bit 5 goes high when the flash has run past its internal time limit.

Reads are taken in pairs, and bit 6 of the two reads is compared. If bit 6 is steady, the operation has finished. If bit 6 flipped while bit 5 was clear, the block keeps polling. If bit 6 flipped while bit 5 was set, the block takes one more pair of reads. This recheck covers the case where toggling stopped at the same moment bit 5 rose. If bit 6 still flips on the recheck, the operation has failed: the block writes the reset command, and only then reports the failure.

An abort input drops the sequence at any point. The next start always begins again with a fresh first pair, with no memory of the aborted run. An optional limit on the number of ordinary read pairs ends a run that never settles.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is held and after it is released, bus_req, done, pass and fail are all low until a start is seen.
- R2: A start pulse while idle makes bus_req high with bus_we low in the next cycle, with bus_addr equal to poll_addr. A request holds bus_we and bus_wdata steady until bus_ready is high.
- R3: If bit 6 of the second read of a pair equals bit 6 of the first read, done and pass pulse in the cycle after the second read is accepted, and no write is issued.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 0, another pair of reads follows without any done.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 1, exactly one recheck pair follows. A steady bit 6 on the recheck gives done with pass.
- R6: If bit 6 still differs on the recheck pair, the block issues one write (bus_we high) with data 0xF0. Done with fail pulses in the cycle after that write is accepted, and never before.
- R7: Abort returns the block to idle with no done, no pass and no fail. The next start begins with a fresh first pair, and any pending recheck is forgotten.
- R8: When WDOG_PAIRS is nonzero and WDOG_PAIRS consecutive pairs toggle with bit 5 at 0, the block writes 0xF0 and then reports done with fail.
- R9: done lasts one cycle. pass and fail are high only together with done, and exactly one of them is high then.
- R10: When abort and bus_ready are high in the same cycle, abort wins: the accepted read yields no done in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (used only when idle) |
| abort | input | 1 | Drop the current sequence |
| poll_addr | input | ADDR_W | Fixed address for status reads and the reset write |
| bus_req | output | 1 | Bus transaction requested |
| bus_we | output | 1 | 1 = write (reset command), 0 = read |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data (0xF0 during a write, else 0) |
| bus_rdata | input | DATA_W | Read data, valid when bus_ready is high |
| bus_ready | input | 1 | Completes the current transaction |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded (with done) |
| fail | output | 1 | Operation failed (with done) |

## Verification
An abort can land in the same cycle that the bus completes the very read that would have ended the run with a pass. The bench sets up that collision on purpose: it drives abort and bus_ready together on the second read of a steady pair. It then requires that no done appears in the following cycles, and that a fresh start behaves as a clean first pair. A second collision, between an abort and a pending recheck, is provoked the same way: the abort comes right after a pair with bit 5 set. The bench then requires that a following toggling pair with bit 5 at 0 is treated as ordinary polling rather than as a failed recheck.

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int WDOG_PAIRS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  localparam int TOG_BIT = 6;
  localparam int TMO_BIT = 5;
  localparam int CW      = (WDOG_PAIRS > 1) ? $clog2(WDOG_PAIRS + 1) : 1;
  localparam int WD_LAST = (WDOG_PAIRS > 0) ? WDOG_PAIRS - 1 : 0;
  localparam logic [DATA_W-1:0] RST_CMD = DATA_W'(8'hF0);

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_RST} state_t;

  state_t          state;
  logic            first_t6, recheck;
  logic [CW-1:0]   pair_cnt;
  logic            done_q, pass_q, fail_q;

  wire toggled = bus_rdata[TOG_BIT] ^ first_t6;
  wire wd_hit  = (WDOG_PAIRS != 0) && (pair_cnt == CW'(WD_LAST));
  wire unused_rdata = ^bus_rdata;

  assign bus_req   = (state != S_IDLE);
  assign bus_we    = (state == S_RST);
  assign bus_addr  = poll_addr;
  assign bus_wdata = bus_we ? RST_CMD : '0;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      first_t6 <= 1'b0;
      recheck  <= 1'b0;
      pair_cnt <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      if (abort) begin
        state    <= S_IDLE;
        recheck  <= 1'b0;
        pair_cnt <= '0;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            state    <= S_RD1;
            recheck  <= 1'b0;
            pair_cnt <= '0;
          end
          S_RD1: if (bus_ready) begin
            first_t6 <= bus_rdata[TOG_BIT];
            state    <= S_RD2;
          end
          S_RD2: if (bus_ready) begin
            if (!toggled) begin
              done_q <= 1'b1;
              pass_q <= 1'b1;
              state  <= S_IDLE;
            end else if (recheck) begin
              state <= S_RST;
            end else if (bus_rdata[TMO_BIT]) begin
              recheck <= 1'b1;
              state   <= S_RD1;
            end else if (wd_hit) begin
              state <= S_RST;
            end else begin
              pair_cnt <= pair_cnt + 1'b1;
              state    <= S_RD1;
            end
          end
          S_RST: if (bus_ready) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
            state  <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module flash_toggle_poller_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ready,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              done,
  input logic              pass,
  input logic              fail
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_verdict_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done ? (pass ^ fail) : (!pass && !fail));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready && !abort) |=> (bus_req && $stable(bus_we) && $stable(bus_wdata)));

  p_fail_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(bus_req && bus_we && bus_ready && !abort));

  p_reset_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata == DATA_W'(8'hF0)));

  p_pass_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> $past(bus_req && !bus_we && bus_ready && !abort));

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !done);
endmodule

bind flash_toggle_poller flash_toggle_poller_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .bus_req(bus_req), .bus_we(bus_we),
  .bus_ready(bus_ready), .bus_wdata(bus_wdata), .done(done), .pass(pass), .fail(fail)
);

// File: tb/tb_flash_toggle_poller.sv
module tb_flash_toggle_poller;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int WD = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, abort = 1'b0, ready = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [DW-1:0] rdata = '0;
  logic          bus_req, bus_we, done, pass, fail;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  flash_toggle_poller #(.ADDR_W(AW), .DATA_W(DW), .WDOG_PAIRS(WD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .poll_addr(poll_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .bus_ready(ready), .done(done), .pass(pass), .fail(fail)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [DW-1:0] rv [0:31];

  int r_nrd, r_nwr;
  bit r_done, r_pass, r_fail, r_badaddr, r_badwd, r_long, r_firstreq;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void predict(output bit is_fail, output int nreads);
    bit rc = 0;
    int pairs = 0;
    int idx = 0;
    is_fail = 0;
    nreads = 0;
    for (int k = 0; k < 15; k++) begin
      logic [DW-1:0] a = rv[idx];
      logic [DW-1:0] b = rv[idx+1];
      idx += 2;
      nreads = idx;
      if (a[6] == b[6]) begin is_fail = 0; return; end
      if (rc) begin is_fail = 1; return; end
      if (b[5]) rc = 1;
      else begin
        pairs++;
        if (pairs == WD) begin is_fail = 1; return; end
      end
    end
  endfunction

  task automatic run_op(input int abort_at, input bit abort_rdy);
    int wt = $urandom_range(0, 2);
    r_nrd = 0; r_nwr = 0; r_done = 0; r_pass = 0; r_fail = 0;
    r_badaddr = 0; r_badwd = 0; r_long = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_firstreq = bus_req && !bus_we && (bus_addr == poll_addr);
    for (int c = 0; c < 400; c++) begin
      ready = 1'b0;
      if (done) begin
        r_done = 1; r_pass = pass; r_fail = fail;
        @(negedge clk);
        r_long = done;
        return;
      end
      if (bus_req) begin
        if (bus_addr != poll_addr) r_badaddr = 1;
        if (abort_at >= 0 && r_nrd == abort_at && !bus_we) begin
          abort = 1'b1;
          ready = abort_rdy;
          rdata = rv[r_nrd];
          @(negedge clk);
          abort = 1'b0;
          ready = 1'b0;
          return;
        end
        if (wt > 0) wt--;
        else begin
          ready = 1'b1;
          wt = $urandom_range(0, 2);
          if (bus_we) begin
            r_nwr++;
            if (bus_wdata != 8'hF0) r_badwd = 1;
          end else begin
            rdata = rv[r_nrd];
            r_nrd++;
          end
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic judge(input string tag);
    bit ef;
    int en;
    predict(ef, en);
    chk(r_firstreq, "R2 first read request", r_firstreq, 1);
    chk(r_done, {tag, " done seen"}, r_done, 1);
    chk(r_fail == ef && r_pass == !ef, {tag, " verdict fail"}, r_fail, ef);
    chk(r_nrd == en, {tag, " read count"}, r_nrd, en);
    chk(r_nwr == (ef ? 1 : 0), "R6 reset write count", r_nwr, ef ? 1 : 0);
    chk(!r_badwd, "R6 reset data 0xF0", r_badwd, 0);
    chk(!r_badaddr, "R2 address", r_badaddr, 0);
    chk(!r_long && (r_pass ^ r_fail), "R9 pulse/exclusive", r_long, 0);
  endtask

  task automatic check_quiet(input string tag);
    for (int i = 0; i < 3; i++) begin
      chk(!done && !pass && !fail && !bus_req, tag, done, 0);
      @(negedge clk);
    end
  endtask

  function automatic logic [DW-1:0] mk(input bit t6, input bit t5);
    logic [DW-1:0] v = DW'($urandom);
    v[6] = t6;
    v[5] = t5;
    return v;
  endfunction

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk(!bus_req && !done && !pass && !fail, "R1 during reset", bus_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !done && !pass && !fail, "R1 after reset", bus_req, 0);

    // R3: steady pair
    poll_addr = 17'h1ABCD;
    rv[0] = mk(1, 0); rv[1] = mk(1, 1);
    run_op(-1, 0); judge("R3");

    // R4: toggle with bit5 low, then steady
    rv[0] = mk(0, 0); rv[1] = mk(1, 0); rv[2] = mk(0, 0); rv[3] = mk(0, 0);
    run_op(-1, 0); judge("R4");

    // R5: toggle with bit5 high, recheck steady
    rv[0] = mk(0, 0); rv[1] = mk(1, 1); rv[2] = mk(1, 1); rv[3] = mk(1, 1);
    run_op(-1, 0); judge("R5");

    // R6: recheck still toggles
    rv[0] = mk(1, 0); rv[1] = mk(0, 1); rv[2] = mk(0, 1); rv[3] = mk(1, 0);
    run_op(-1, 0); judge("R6");

    // R8: watchdog after WD toggling pairs
    for (int i = 0; i < 32; i++) rv[i] = mk(i[0], 0);
    run_op(-1, 0); judge("R8");

    // R10: abort collides with accept of a steady second read
    rv[0] = mk(1, 0); rv[1] = mk(1, 0);
    run_op(1, 1);
    check_quiet("R10 abort with ready gives no done");

    // R7: abort right after a bit5 pair, then fresh start
    rv[0] = mk(0, 0); rv[1] = mk(1, 1); rv[2] = mk(1, 0);
    run_op(2, 0);
    check_quiet("R7 abort leaves block idle");
    rv[0] = mk(0, 0); rv[1] = mk(1, 0); rv[2] = mk(1, 0); rv[3] = mk(1, 0);
    run_op(-1, 0); judge("R7 restart from top");

    // random operations
    for (int n = 0; n < 40; n++) begin
      poll_addr = AW'($urandom);
      for (int i = 0; i < 32; i++)
        rv[i] = mk($urandom_range(0, 1), $urandom_range(0, 3) == 0);
      run_op(-1, 0);
      judge("R3/R4/R5/R6 random");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule